// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio M·N + A. It is the feedback path of a frequency synthesizer. A dual-modulus prescaler, modelled here as a small digital counter, divides by M or by M+1. A swallow counter keeps the prescaler at M+1 for the first A prescaler periods of each output period. After that the prescaler runs at M until a main counter has seen N prescaler periods in total. At that point the block emits one single-clock output pulse, and both counters reload.

Software presents N, A and a modulus-select bit on the input pins and strobes `load`. The strobe captures them into a holding stage. The running output period always completes with the ratio it started with, and the new ratio begins at the next period boundary.

When `en` is low, the counters are held cleared and the output stays quiet. The same happens while the active settings are illegal, and `cfg_err` flags that case.

Top module: `pswl_divider`

## Requirements
- R1: The number of `clk_in` rising edges between two consecutive `div_out` pulses equals M·N + A for the active settings, with N from 3 to 2047 and A from 0 to 127.
- R2: `div_out` is high for exactly one `clk_in` cycle per output period.
- R3: Each output period starts with A prescaler periods of M+1 input clocks, followed by N−A periods of M clocks. An A of 0 gives exactly M·N, and an A of N−1 gives M·N + N − 1.
- R4: `n_val`, `a_val` and `mod_sel` are captured only on a cycle where `load` is high. Changing them with `load` low does not alter the output period.
- R5: A load that arrives mid-period does not change that period's length. The captured settings govern the period that starts at the next boundary.
- R6: While `en` is low, `div_out` stays low and the counters are held cleared. After `en` rises, the first pulse appears on the M·N + A-th rising edge, counting the first edge at which `en` is high.
- R7: `cfg_err` is high whenever the active N is below 3 or the active A is not less than N. While it is high, no pulse is produced. While held, the active settings follow the captured ones on every clock. After a legal load, the first pulse comes M·N + A + 1 edges after the capturing edge.
- R8: During and after reset, `div_out` is 0 and the captured and active N and A are 0, so `cfg_err` reads 1 until a legal load.
- R9: With `mod_sel` = 1, M = P_LO (default 8). With `mod_sel` = 0, M = P_HI (default 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low selects power saving |
| mod_sel | input | 1 | Prescaler pair select: 1 = P_LO, 0 = P_HI |
| n_val | input | 11 | Main counter value N |
| a_val | input | 7 | Swallow counter value A |
| load | input | 1 | Capture strobe for n_val, a_val, mod_sel |
| div_out | output | 1 | One-clock pulse per full division period |
| cfg_err | output | 1 | Active settings are illegal; counting held |

## Verification
The hardest situation to reach is a settings change that lands in the middle of a running period. It is also hard to reach the exit from the illegal-settings hold, where the active registers are reloaded on every clock. The stimulus reaches both directly. It places a load a fixed number of clocks after an observed pulse and then measures the next two periods separately: the first must keep the old ratio and the second must take the new one. It loads illegal pairs, both A equal to N and N below 3, and then a legal pair, and it times the recovery pulse to the exact edge. Random legal ratios across both prescaler pairs, plus the largest ratio, cover the counting arithmetic.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

  // Legal setting: main count at least 3 and swallow count below it.
  function automatic logic ratio_ok(input int unsigned n, input int unsigned a);
    return (n >= 32'd3) && (a < n);
  endfunction

  // Total input clocks per output period.
  function automatic int unsigned total_ratio(input int unsigned m,
                                              input int unsigned n,
                                              input int unsigned a);
    return m * n + a;
  endfunction

endpackage

// File: rtl/pswl_cfg.sv
module pswl_cfg #(
  parameter int N_W = 11,
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  input  logic           sel_in,
  input  logic           take,
  output logic [N_W-1:0] sh_n,
  output logic [A_W-1:0] sh_a,
  output logic           sh_sel,
  output logic [N_W-1:0] act_n,
  output logic [A_W-1:0] act_a,
  output logic           act_sel
);

  // Holding stage written by the strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_n   <= '0;
      sh_a   <= '0;
      sh_sel <= 1'b1;
    end else if (load) begin
      sh_n   <= n_in;
      sh_a   <= a_in;
      sh_sel <= sel_in;
    end
  end

  // Active stage, moved only at a boundary or while held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_n   <= '0;
      act_a   <= '0;
      act_sel <= 1'b1;
    end else if (take) begin
      act_n   <= sh_n;
      act_a   <= sh_a;
      act_sel <= sh_sel;
    end
  end

endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
  parameter int P_LO = 8,
  parameter int P_HI = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel,
  input  logic swallow,
  output logic pre_end
);

  localparam int PMAX = (P_HI > P_LO) ? P_HI : P_LO;
  localparam int CW   = $clog2(PMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    last    = (sel ? CW'(P_LO - 1) : CW'(P_HI - 1)) + CW'(swallow);
    pre_end = !clr && (cnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (pre_end) cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/pswl_counters.sv
module pswl_counters #(
  parameter int N_W = 11,
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           pre_end,
  input  logic [N_W-1:0] ld_n,
  input  logic [A_W-1:0] ld_a,
  output logic           swallow_on,
  output logic           cyc_end
);

  logic [N_W-1:0] n_left;
  logic [A_W-1:0] a_left;

  assign swallow_on = (a_left != '0);
  assign cyc_end    = !clr && pre_end && (n_left == N_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_left <= '0;
      a_left <= '0;
    end else if (clr || cyc_end) begin
      n_left <= ld_n;
      a_left <= ld_a;
    end else if (pre_end) begin
      n_left <= n_left - N_W'(1);
      if (swallow_on) a_left <= a_left - A_W'(1);
    end
  end

endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
  parameter int P_LO = 8,
  parameter int P_HI = 16,
  parameter int N_W  = 11,
  parameter int A_W  = 7
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic           en,
  input  logic           mod_sel,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  input  logic           load,
  output logic           div_out,
  output logic           cfg_err
);
  import pswl_pkg::*;

  logic [N_W-1:0] sh_n, act_n;
  logic [A_W-1:0] sh_a, act_a;
  logic           sh_sel, act_sel;
  logic           hold, take, pre_end, swallow_on, cyc_end;

  assign cfg_err = !ratio_ok(32'(act_n), 32'(act_a));
  assign hold    = !en || cfg_err;
  assign take    = hold || cyc_end;

  pswl_cfg #(.N_W(N_W), .A_W(A_W)) u_cfg (
    .clk(clk_in), .rst_n(rst_n), .load(load),
    .n_in(n_val), .a_in(a_val), .sel_in(mod_sel), .take(take),
    .sh_n(sh_n), .sh_a(sh_a), .sh_sel(sh_sel),
    .act_n(act_n), .act_a(act_a), .act_sel(act_sel)
  );

  pswl_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk(clk_in), .rst_n(rst_n), .clr(hold), .sel(act_sel),
    .swallow(swallow_on), .pre_end(pre_end)
  );

  pswl_counters #(.N_W(N_W), .A_W(A_W)) u_cnt (
    .clk(clk_in), .rst_n(rst_n), .clr(hold), .pre_end(pre_end),
    .ld_n(sh_n), .ld_a(sh_a), .swallow_on(swallow_on), .cyc_end(cyc_end)
  );

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) div_out <= 1'b0;
    else        div_out <= cyc_end;
  end

endmodule

// File: rtl/pswl_divider_chk.sv
module pswl_divider_chk #(
  parameter int N_W = 11,
  parameter int A_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           div_out,
  input logic           cfg_err,
  input logic           hold,
  input logic           pre_end,
  input logic           swallow_on,
  input logic           cyc_end,
  input logic [N_W-1:0] act_n,
  input logic [A_W-1:0] act_a,
  input logic           act_sel
);

  logic [N_W-1:0] pe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pe_cnt <= '0;
    else if (hold || cyc_end)  pe_cnt <= '0;
    else if (pre_end)          pe_cnt <= pe_cnt + N_W'(1);
  end

  // R1: a period closes after exactly N prescaler periods
  a_r1_main_count: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> (pe_cnt + N_W'(1) == act_n));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  // R3: swallow phase ends only at a prescaler boundary
  a_r3_swallow_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(swallow_on) && !$past(hold)) |-> $past(pre_end));

  a_r5_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_end && !hold) |=> ($stable(act_n) && $stable(act_a) && $stable(act_sel)));

  a_r6_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !div_out);

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !div_out);

endmodule

bind pswl_divider pswl_divider_chk #(.N_W(N_W), .A_W(A_W)) u_chk (
  .clk(clk_in), .rst_n(rst_n), .en(en), .div_out(div_out), .cfg_err(cfg_err),
  .hold(hold), .pre_end(pre_end), .swallow_on(swallow_on), .cyc_end(cyc_end),
  .act_n(act_n), .act_a(act_a), .act_sel(act_sel)
);

// File: tb/pswl_divider_tb.sv
module pswl_divider_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        mod_sel = 1'b1;
  logic [10:0] n_val = '0;
  logic [6:0]  a_val = '0;
  logic        load = 1'b0;
  logic        div_out, cfg_err;

  int unsigned ticks = 0;
  int          checks = 0;
  int          fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ticks <= ticks + 1;

  pswl_divider u_dut (
    .clk_in(clk), .rst_n(rst_n), .en(en), .mod_sel(mod_sel),
    .n_val(n_val), .a_val(a_val), .load(load),
    .div_out(div_out), .cfg_err(cfg_err)
  );

  function automatic int unsigned exp_ratio(input bit sel, input int unsigned n,
                                            input int unsigned a);
    int unsigned m;
    m = sel ? 8 : 16;
    return n * m + a;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input bit sel, input int unsigned n, input int unsigned a);
    @(negedge clk);
    mod_sel = sel; n_val = n[10:0]; a_val = a[6:0]; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_pulse(output int unsigned at);
    int unsigned guard;
    guard = 0;
    @(negedge clk);
    while (!div_out && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
    if (!div_out) check(1'b0, "R1 pulse timeout", guard, 0);
    at = ticks;
  endtask

  task automatic count_quiet(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (div_out) pulses++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned t0, t1, t2, ts, r;
    int          q;
    void'($urandom(32'd7211));

    // R8: reset state
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R8 div_out in reset", div_out, 0);
    check(cfg_err == 1'b1, "R8 cfg_err in reset", cfg_err, 1);
    rst_n = 1'b1;
    count_quiet(20, q);
    check(q == 0, "R8 no pulse before legal load", q, 0);
    check(cfg_err == 1'b1, "R8 cfg_err after reset", cfg_err, 1);

    // R1/R9 smallest ratio, low pair, A = N-1 (R3)
    do_load(1'b1, 3, 2);
    wait_pulse(t0); wait_pulse(t1);
    check(t1 - t0 == exp_ratio(1, 3, 2), "R3 min ratio A=N-1", t1 - t0, exp_ratio(1, 3, 2));

    // R3: A = 0 on the high pair (R9)
    do_load(1'b0, 9, 0);
    wait_pulse(t0); wait_pulse(t1);
    check(t1 - t0 == exp_ratio(0, 9, 0), "R9 high pair A=0", t1 - t0, exp_ratio(0, 9, 0));

    // R5: mid-period load keeps old length, then switches
    do_load(1'b1, 10, 3);
    wait_pulse(t0);
    repeat (20) @(negedge clk);
    do_load(1'b0, 6, 2);
    wait_pulse(t1);
    check(t1 - t0 == exp_ratio(1, 10, 3), "R5 running period kept", t1 - t0, exp_ratio(1, 10, 3));
    wait_pulse(t2);
    check(t2 - t1 == exp_ratio(0, 6, 2), "R5 new period applied", t2 - t1, exp_ratio(0, 6, 2));

    // R4: inputs change without load
    @(negedge clk);
    mod_sel = 1'b1; n_val = 11'd40; a_val = 7'd5;
    wait_pulse(t1); wait_pulse(t2);
    check(t2 - t1 == exp_ratio(0, 6, 2), "R4 no capture without load", t2 - t1, exp_ratio(0, 6, 2));

    // R2: pulse lasts one cycle
    @(negedge clk);
    check(div_out == 1'b0, "R2 pulse width", div_out, 0);

    // R6: power save then release
    @(negedge clk); en = 1'b0;
    do_load(1'b1, 4, 1);
    count_quiet(60, q);
    check(q == 0, "R6 quiet while disabled", q, 0);
    @(negedge clk); en = 1'b1; ts = ticks;
    wait_pulse(t0);
    check(t0 - ts == exp_ratio(1, 4, 1), "R6 first pulse latency", t0 - ts, exp_ratio(1, 4, 1));

    // R7: illegal A = N, taken at boundary
    do_load(1'b1, 5, 5);
    wait_pulse(t0);
    check(cfg_err == 1'b1, "R7 err after A=N", cfg_err, 1);
    count_quiet(80, q);
    check(q == 0, "R7 quiet in error", q, 0);
    do_load(1'b1, 2, 0);
    @(negedge clk);
    check(cfg_err == 1'b1, "R7 err for N=2", cfg_err, 1);
    do_load(1'b0, 5, 4);
    ts = ticks;
    @(negedge clk);
    check(cfg_err == 1'b0, "R7 err clears", cfg_err, 0);
    wait_pulse(t0);
    check(t0 - ts == exp_ratio(0, 5, 4) + 1, "R7 recovery latency", t0 - ts, exp_ratio(0, 5, 4) + 1);

    // R1: random legal ratios on both pairs
    for (int k = 0; k < 20; k++) begin
      bit          s;
      int unsigned n, a;
      s = $urandom_range(1, 0);
      n = $urandom_range(42, 3);
      a = $urandom_range(n - 1, 0);
      if (a > 127) a = 127;
      do_load(s, n, a);
      wait_pulse(t0); wait_pulse(t1);
      r = exp_ratio(s, n, a);
      check(t1 - t0 == r, "R1 random ratio", t1 - t0, r);
    end

    // R1: largest ratio
    do_load(1'b0, 2047, 127);
    wait_pulse(t0); wait_pulse(t1);
    check(t1 - t0 == exp_ratio(0, 2047, 127), "R1 max ratio", t1 - t0, exp_ratio(0, 2047, 127));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule